// File: doc/BRIEF.md
# Interrupt and Hold-Wakeup Controller

This block gathers five event sources for a small processor core. The sources are a divider overflow pulse, two timer underflow pulses, a change on a multi-bit input port, and a falling edge on an external active-low interrupt pin. Each event is latched into its own flag. The flag stays set until the CPU accepts the interrupt or reset clears it.

Two write-only 8-bit enable masks decide what the flags do. One mask decides which flags release the core from hold (sleep); the result is the `wake` output. The other mask decides which flags request an interrupt. When the CPU acknowledges, the block reports the number of the highest-priority pending source and clears only that flag. It then blocks every further interrupt until software re-enables them.

The bit assignment is the same in both masks:

| Bit | Source |
|-----|--------|
| 0 | divider 0 overflow |
| 1 | timer 0 underflow |
| 2 | input port change |
| 4 | external pin falling edge |
| 7 | timer 1 underflow |

Bits 3, 5 and 6 are unused.

Top module: `evt_wake_irq`

## Requirements
- R1: A write (`cfg_we`=1) loads `cfg_data` into the hold mask when `cfg_sel`=0 and into the interrupt mask when `cfg_sel`=1. In both masks bit 0 is divider 0 overflow, bit 1 is timer 0 underflow, bit 2 is a port change, bit 4 is a falling edge on the external pin, and bit 7 is timer 1 underflow.
- R2: Bits 3, 5 and 6 of both masks have no effect on `wake`, `irq_req` or `irq_id`.
- R3: `wake` is 1 while any flag whose hold-mask bit is 1 is set, and 0 otherwise. It does not depend on the interrupt mask or on the global interrupt gate.
- R4: A flag stays set while its enable bits are 0. Writing a 1 to its interrupt-mask bit raises `irq_req` in the cycle after the write.
- R5: When several enabled flags are set, `irq_id` gives the lowest bit number among them, as a binary number 0, 1, 2, 4 or 7.
- R6: An acceptance (`irq_ack`=1 while `irq_req`=1) clears only the flag named by `irq_id`. If a new event from the same source arrives in the same cycle, the flag stays set.
- R7: After an acceptance, `irq_req` stays 0 until `glb_en` is pulsed or the interrupt mask is written.
- R8: While `glb_dis` is pulsed, interrupts are blocked from the next cycle whatever the mask holds. `glb_dis` takes priority over `glb_en` and over a mask write in the same cycle.
- R9: The external pin passes through two synchronizer flip-flops. Only a 1-to-0 transition sets flag 4, and the flag is set at the third rising clock edge after the pin falls. A rising transition sets no flag.
- R10: The port passes through two synchronizer flip-flops. A change of any bit, in either direction, sets flag 2.
- R11: A timer or divider pulse that is 1 at a rising edge sets its flag at that edge.
- R12: Reset clears all flags and both masks and leaves interrupts globally disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div0_ovf | input | 1 | Divider 0 overflow pulse |
| tmr0_unf | input | 1 | Timer 0 underflow pulse |
| tmr1_unf | input | 1 | Timer 1 underflow pulse |
| port_in | input | PORT_W | Asynchronous input port |
| ext_n | input | 1 | Asynchronous external interrupt pin, active low |
| cfg_we | input | 1 | Mask write strobe |
| cfg_sel | input | 1 | Mask select: 0 selects the hold mask, 1 selects the interrupt mask |
| cfg_data | input | 8 | Mask write data |
| glb_en | input | 1 | Global interrupt enable command |
| glb_dis | input | 1 | Global interrupt disable command |
| irq_ack | input | 1 | CPU acknowledge |
| wake | output | 1 | Hold-release request |
| irq_req | output | 1 | Interrupt request |
| irq_id | output | 3 | Number of the source being accepted |

## Verification
Two functions can meet in one cycle: an acceptance clears a source's flag, and a fresh pulse from that same source tries to set it. The bench provokes this by raising `irq_ack` together with `tmr0_unf` while flag 1 is pending. It then pulses `glb_en` and expects `irq_req` to return with `irq_id`=1. A control run, with the acknowledge alone, must leave `irq_req` at 0 after the same `glb_en`. The bench also collides `glb_dis` with `glb_en` and with a mask write, and expects the disable to win.

// File: rtl/evt_wake_irq.sv
module evt_wake_irq #(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div0_ovf,
  input  logic              tmr0_unf,
  input  logic              tmr1_unf,
  input  logic [PORT_W-1:0] port_in,
  input  logic              ext_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [7:0]        cfg_data,
  input  logic              glb_en,
  input  logic              glb_dis,
  input  logic              irq_ack,
  output logic              wake,
  output logic              irq_req,
  output logic [2:0]        irq_id
);
  localparam logic [7:0] LIVE = 8'b1001_0111;

  logic [7:0] hold_en, irq_en, flags, pend, raw, clr;
  logic       gie, accept;
  logic [1:0] ext_s;
  logic       ext_q;
  logic [PORT_W-1:0] port_s1, port_s2, port_q;

  wire ext_fall = ext_q & ~ext_s[1];
  wire port_chg = |(port_s2 ^ port_q);
  wire ien_wr   = cfg_we & cfg_sel;

  assign raw     = {tmr1_unf, 2'b00, ext_fall, 1'b0, port_chg, tmr0_unf, div0_ovf};
  assign pend    = flags & irq_en & LIVE;
  assign wake    = |(flags & hold_en & LIVE);
  assign irq_req = gie & |pend;
  assign accept  = irq_ack & irq_req;
  assign clr     = accept ? (8'd1 << irq_id) : 8'd0;

  always_comb begin
    irq_id = 3'd0;
    for (int i = 7; i >= 0; i--)
      if (pend[i]) irq_id = 3'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_s   <= 2'b11;
      ext_q   <= 1'b1;
      port_s1 <= '0;
      port_s2 <= '0;
      port_q  <= '0;
    end else begin
      ext_s   <= {ext_s[0], ext_n};
      ext_q   <= ext_s[1];
      port_s1 <= port_in;
      port_s2 <= port_s1;
      port_q  <= port_s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_en <= '0;
      irq_en  <= '0;
      flags   <= '0;
      gie     <= 1'b0;
    end else begin
      if (cfg_we && !cfg_sel) hold_en <= cfg_data;
      if (ien_wr) irq_en <= cfg_data;
      flags <= ((flags & ~clr) | raw) & LIVE;
      if (glb_dis)              gie <= 1'b0;
      else if (glb_en || ien_wr) gie <= 1'b1;
      else if (accept)          gie <= 1'b0;
    end
  end

  // R6
  clear_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ((flags | (8'd1 << $past(irq_id))) & $past(flags)) == $past(flags));

  // R7
  block_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !glb_en && !ien_wr) |=> !irq_req);

  // R8
  global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glb_dis |=> !irq_req);

  // R5
  id_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_id inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd7}));

  // R3
  wake_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (hold_en != 8'd0));
endmodule

// File: tb/tb_evt_wake_irq.sv
module tb_evt_wake_irq;
  logic clk = 0, rst_n = 0;
  logic div0_ovf = 0, tmr0_unf = 0, tmr1_unf = 0;
  logic [3:0] port_in = 0;
  logic ext_n = 1, cfg_we = 0, cfg_sel = 0, glb_en = 0, glb_dis = 0, irq_ack = 0;
  logic [7:0] cfg_data = 0;
  logic wake, irq_req;
  logic [2:0] irq_id;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  evt_wake_irq #(.PORT_W(4)) dut (.*);

  // {events, irq mask, hold mask}
  localparam logic [23:0] VEC [8] = '{
    24'h01_01_00, 24'h82_00_82, 24'h83_83_01, 24'h82_80_02,
    24'h81_FF_FF, 24'h02_68_02, 24'h80_97_00, 24'h03_02_68};

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic do_reset;
    rst_n = 0; tick; rst_n = 1;
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_data = d; tick; cfg_we = 0;
  endtask

  task automatic pulse(logic [7:0] ev);
    div0_ovf = ev[0]; tmr0_unf = ev[1]; tmr1_unf = ev[7]; tick;
    div0_ovf = 0; tmr0_unf = 0; tmr1_unf = 0;
  endtask

  task automatic gen; glb_en = 1; tick; glb_en = 0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick; tick;
    rst_n = 1;
    chk("R12 wake", {7'd0, wake}, 0);
    chk("R12 irq", {7'd0, irq_req}, 0);

    foreach (VEC[k]) begin
      logic [7:0] ev = VEC[k][23:16], ie = VEC[k][15:8], he = VEC[k][7:0];
      logic [7:0] p = ev & ie & 8'h97;
      logic [2:0] eid = 0;
      for (int i = 7; i >= 0; i--) if (p[i]) eid = 3'(i);
      do_reset; wr(0, he); wr(1, ie); pulse(ev);
      chk("R1 R2 R3 R11 wake", {7'd0, wake}, {7'd0, |(ev & he & 8'h97)});
      chk("R1 R2 irq", {7'd0, irq_req}, {7'd0, |p});
      if (|p) begin
        irq_ack = 1;
        chk("R5 id", {5'd0, irq_id}, {5'd0, eid});
        tick; irq_ack = 0;
        chk("R7 blocked", {7'd0, irq_req}, 0);
      end
    end

    // R4: flag held while disabled, late enable raises request
    do_reset; wr(1, 8'h68); pulse(8'h83);
    chk("R2 reserved only", {7'd0, irq_req}, 0);
    wr(1, 8'h80);
    chk("R4 late enable", {7'd0, irq_req}, 1);
    chk("R4 id", {5'd0, irq_id}, 7);

    // R7: after acceptance, other pending blocked until glb_en
    wr(1, 8'h81);
    irq_ack = 1; chk("R5 lowest", {5'd0, irq_id}, 0); tick; irq_ack = 0;
    chk("R7 other pending blocked", {7'd0, irq_req}, 0);
    gen;
    chk("R7 glb_en restores", {7'd0, irq_req}, 1);
    chk("R6 other flag kept", {5'd0, irq_id}, 7);

    // R8: disable, and its priority over enable and write
    glb_dis = 1; tick; glb_dis = 0;
    chk("R8 disable", {7'd0, irq_req}, 0);
    glb_dis = 1; glb_en = 1; cfg_we = 1; cfg_sel = 1; cfg_data = 8'h81; tick;
    glb_dis = 0; glb_en = 0; cfg_we = 0;
    chk("R8 disable wins", {7'd0, irq_req}, 0);

    // R6: ack collides with new event on same source
    do_reset; wr(1, 8'h02); pulse(8'h02);
    irq_ack = 1; tmr0_unf = 1; tick; irq_ack = 0; tmr0_unf = 0;
    gen;
    chk("R6 collision keeps flag", {7'd0, irq_req}, 1);
    irq_ack = 1; tick; irq_ack = 0; gen;
    chk("R6 plain ack clears", {7'd0, irq_req}, 0);

    // R9: external pin falling edge
    do_reset; wr(1, 8'h10); wr(0, 8'h10);
    ext_n = 0; tick; tick;
    chk("R9 not yet", {7'd0, irq_req}, 0);
    tick;
    chk("R9 fall", {7'd0, irq_req}, 1);
    chk("R3 wake pin", {7'd0, wake}, 1);
    irq_ack = 1; chk("R9 id", {5'd0, irq_id}, 4); tick; irq_ack = 0;
    gen; ext_n = 1; repeat (4) tick;
    chk("R9 rise ignored", {7'd0, irq_req}, 0);
    chk("R3 wake drop", {7'd0, wake}, 0);

    // R10: port change either direction
    do_reset; wr(1, 8'h04);
    port_in = 4'h5; repeat (3) tick;
    chk("R10 rise", {7'd0, irq_req}, 1);
    irq_ack = 1; chk("R10 id", {5'd0, irq_id}, 2); tick; irq_ack = 0;
    gen; repeat (3) tick;
    chk("R10 stable", {7'd0, irq_req}, 0);
    port_in = 4'h4; repeat (3) tick;
    chk("R10 fall", {7'd0, irq_req}, 1);

    // R3: wake independent of interrupt gate
    do_reset; wr(0, 8'h01); pulse(8'h01);
    chk("R3 wake no irq mask", {7'd0, wake}, 1);
    chk("R3 no irq", {7'd0, irq_req}, 0);

    // R12: reset clears flags
    do_reset; wr(1, 8'hFF); wr(0, 8'hFF);
    chk("R12 flags cleared", {6'd0, wake, irq_req}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule